// File: doc/BRIEF.md
# Long-Mode Interrupt Dispatch Sequencer

This block delivers a vectored interrupt or trap for a 64-bit core when the handler runs on the current stack. A one-cycle start pulse captures the vector, the interrupt table base, the two descriptor table bases and the architectural state of the interrupted context: instruction pointer, stack pointer, code and stack selectors, and flags. The sequencer then fetches the 16-byte gate and the target code descriptor over a read port and validates them. It computes the aligned handler stack and pushes a five-word return frame over a write port.

When every check passes, the block updates its registered outputs: the handler instruction pointer, code selector, stack pointer and flags. When a check fails, it reports a fault code instead. No write is issued and no output register moves until all fault decisions are taken. Gates that would need a stack switch are refused with an "unsupported" code, so a slower path can handle them. Both memory ports use a request/ready handshake with arbitrary latency, and only one transaction is outstanding at a time.

Top module: `intr_dispatch_seq`

## Requirements
- R1: The first read address is `vec_tbl_base + (vector << 4)` and the second read address is 8 higher. These two words are the gate's low and high halves.
- R2: If bits 43:41 of the low gate word are not all ones, the sequence ends with `fault_code` = 1 (general protection). No write is issued.
- R3: The gate's code selector is low-word bits 31:16. The third read address is `global_tbl_base` plus the selector with its low 3 bits cleared when selector bit 2 is 0. When selector bit 2 is 1, `local_tbl_base` is used in place of `global_tbl_base`.
- R4: On success, `new_ip` is {high word 31:0, low word 63:48, low word 15:0}, and `new_cs` is the gate selector.
- R5: If low-word bits 34:32 are nonzero, or code-descriptor bits 46:45 differ from `cur_cs[1:0]`, the sequence ends with `fault_code` = 2 (unsupported). No write is issued.
- R6: On success, `new_sp` is `cur_sp - 40` with bits 3:0 cleared.
- R7: Five 64-bit words are written at `new_sp` + 0, 8, 16, 24 and 32, in that order. They are: the return IP (`cur_ip`), the zero-extended `cur_cs`, `cur_flags`, `cur_sp`, and the zero-extended `cur_ss`.
- R8: On success, `new_flags` is `cur_flags` with bits 8, 14 and 16 cleared. Bit 9 is also cleared when gate low-word bit 40 is 0, and kept when it is 1.
- R9: A faulting sequence leaves `new_ip`, `new_cs`, `new_sp` and `new_flags` at their previous values.
- R10: `busy` is high from the cycle after an accepted start until completion. `done` is a one-cycle pulse with `busy` low, and `fault_code` is valid with it (0 = none). A start pulse while busy has no effect.
- R11: A read or write request, once raised, holds its address and data stable until ready is seen. Any response latency is accepted, and read and write requests are never raised together.
- R12: A synchronous active-high reset returns the block to idle. `busy`, `done` and `fault_code` are then 0, and the output registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a dispatch (ignored while busy) |
| vector | input | VEC_W | Interrupt vector number |
| vec_tbl_base | input | 64 | Interrupt gate table base address |
| local_tbl_base | input | 64 | Local descriptor table base |
| global_tbl_base | input | 64 | Global descriptor table base |
| cur_ip | input | 64 | Return instruction pointer |
| cur_sp | input | 64 | Current stack pointer |
| cur_cs | input | 16 | Current code selector (bits 1:0 = current privilege) |
| cur_ss | input | 16 | Current stack selector |
| cur_flags | input | 64 | Current flags |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 64 | Read address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid (later than acceptance) |
| rd_rdata | input | 64 | Read data |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| fault_code | output | 2 | 0 none, 1 general protection, 2 unsupported |
| new_ip | output | 64 | Handler instruction pointer |
| new_cs | output | 16 | Handler code selector |
| new_sp | output | 64 | Handler stack pointer |
| new_flags | output | 64 | Handler flags |

## Verification
A decode slip, such as a wrong bit range for type, stack index or selector, shows up within one dispatch at the ports. It appears as a wrong third read address, a wrong fault code on the completion pulse, or a wrong handler pointer. A sequencing error has a different signature: frame writes appear after a fault, a frame word lands out of order, or an output register moves on a refused gate. These are visible on the write port or the result registers before or at the same `done` pulse. A handshake error can leave a request dropped or changed before acceptance, which the bench's memory model exposes as missing or misaddressed beats. A hang instead shows as `done` never arriving.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;
  localparam int XLEN        = 64;
  localparam int SEL_W       = 16;
  localparam int FRAME_WORDS = 5;
  localparam int FRAME_BYTES = FRAME_WORDS * 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int ALIGN_BITS  = 4;

  localparam int FL_TRAP   = 8;
  localparam int FL_INTEN  = 9;
  localparam int FL_NEST   = 14;
  localparam int FL_RESUME = 16;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_GP    = 2'd1,
    FLT_UNSUP = 2'd2
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RQ_GLO, S_WT_GLO, S_RQ_GHI, S_WT_GHI, S_CHK_GATE,
    S_RQ_CD, S_WT_CD, S_CHK_STK, S_WRITE
  } state_e;

  typedef struct packed {
    logic [XLEN-1:0]  target;
    logic [SEL_W-1:0] sel;
    logic [2:0]       ist;
    logic [3:0]       gtype;
  } gate_fields_t;

  function automatic logic [XLEN-1:0] gate_addr_f(input logic [XLEN-1:0] base,
                                                  input logic [XLEN-1:0] vec);
    return base + (vec << 4);
  endfunction

  function automatic logic [XLEN-1:0] desc_addr_f(input logic [SEL_W-1:0] sel,
                                                  input logic [XLEN-1:0] ltab,
                                                  input logic [XLEN-1:0] gtab);
    logic [XLEN-1:0] idx;
    idx = {{(XLEN-SEL_W){1'b0}}, sel[SEL_W-1:3], 3'b000};
    return (sel[2] ? ltab : gtab) + idx;
  endfunction

  function automatic logic [XLEN-1:0] stack_top_f(input logic [XLEN-1:0] sp);
    logic [XLEN-1:0] d;
    d = sp - XLEN'(FRAME_BYTES);
    return {d[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] flags_f(input logic [XLEN-1:0] f,
                                              input logic keep_ie);
    logic [XLEN-1:0] r;
    r = f;
    r[FL_TRAP]   = 1'b0;
    r[FL_NEST]   = 1'b0;
    r[FL_RESUME] = 1'b0;
    if (!keep_ie) r[FL_INTEN] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/intr_gate_decode.sv
module intr_gate_decode
  import intr_dispatch_pkg::*;
(
  input  logic [XLEN-1:0] gate_lo,
  input  logic [XLEN-1:0] gate_hi,
  input  logic [XLEN-1:0] code_desc,
  input  logic [1:0]      cur_cpl,
  output gate_fields_t    fields,
  output logic            type_ok,
  output logic            stack_switch
);
  logic [1:0] tgt_dpl;

  always_comb begin
    fields.target = {gate_hi[31:0], gate_lo[63:48], gate_lo[15:0]};
    fields.sel    = gate_lo[31:16];
    fields.ist    = gate_lo[34:32];
    fields.gtype  = gate_lo[43:40];
    tgt_dpl       = code_desc[46:45];
    type_ok       = (gate_lo[43:41] == 3'b111);
    stack_switch  = (fields.ist != 3'd0) || (tgt_dpl != cur_cpl);
  end
endmodule

// File: rtl/intr_frame_sel.sv
module intr_frame_sel
  import intr_dispatch_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  frame_base,
  input  logic [XLEN-1:0]  ret_ip,
  input  logic [SEL_W-1:0] ret_cs,
  input  logic [XLEN-1:0]  ret_flags,
  input  logic [XLEN-1:0]  ret_sp,
  input  logic [SEL_W-1:0] ret_ss,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  data
);
  always_comb begin
    addr = frame_base + {{(XLEN-IDX_W-3){1'b0}}, idx, 3'b000};
    case (idx)
      IDX_W'(0): data = ret_ip;
      IDX_W'(1): data = {{(XLEN-SEL_W){1'b0}}, ret_cs};
      IDX_W'(2): data = ret_flags;
      IDX_W'(3): data = ret_sp;
      default:   data = {{(XLEN-SEL_W){1'b0}}, ret_ss};
    endcase
  end
endmodule

// File: rtl/intr_dispatch_seq.sv
module intr_dispatch_seq
  import intr_dispatch_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] vector,
  input  logic [63:0]      vec_tbl_base,
  input  logic [63:0]      local_tbl_base,
  input  logic [63:0]      global_tbl_base,
  input  logic [63:0]      cur_ip,
  input  logic [63:0]      cur_sp,
  input  logic [15:0]      cur_cs,
  input  logic [15:0]      cur_ss,
  input  logic [63:0]      cur_flags,
  output logic             rd_valid,
  output logic [63:0]      rd_addr,
  input  logic             rd_ready,
  input  logic             rd_rvalid,
  input  logic [63:0]      rd_rdata,
  output logic             wr_valid,
  output logic [63:0]      wr_addr,
  output logic [63:0]      wr_data,
  input  logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       fault_code,
  output logic [63:0]      new_ip,
  output logic [15:0]      new_cs,
  output logic [63:0]      new_sp,
  output logic [63:0]      new_flags
);
  state_e           state;
  logic [VEC_W-1:0] l_vec;
  logic [XLEN-1:0]  l_tbl, l_ltab, l_gtab, l_ip, l_sp, l_flags;
  logic [SEL_W-1:0] l_cs, l_ss;
  logic [XLEN-1:0]  gate_lo, gate_hi, code_desc;
  logic [IDX_W-1:0] wr_idx;
  logic             done_q;
  logic [1:0]       fault_q;
  logic [XLEN-1:0]  ip_q, sp_q, flags_q;
  logic [SEL_W-1:0] cs_q;

  gate_fields_t     gf;
  logic             type_ok, stack_switch;
  logic [XLEN-1:0]  g_addr, cd_addr, frame_base, tgt_flags;

  // named internal events for the checker
  logic ev_accept, ev_gate_fault, ev_stack_fault, ev_wr_beat, ev_commit;

  intr_gate_decode u_dec (
    .gate_lo      (gate_lo),
    .gate_hi      (gate_hi),
    .code_desc    (code_desc),
    .cur_cpl      (l_cs[1:0]),
    .fields       (gf),
    .type_ok      (type_ok),
    .stack_switch (stack_switch)
  );

  assign g_addr     = gate_addr_f(l_tbl, {{(XLEN-VEC_W){1'b0}}, l_vec});
  assign cd_addr    = desc_addr_f(gf.sel, l_ltab, l_gtab);
  assign frame_base = stack_top_f(l_sp);
  assign tgt_flags  = flags_f(l_flags, gf.gtype[0]);

  intr_frame_sel u_frame (
    .idx        (wr_idx),
    .frame_base (frame_base),
    .ret_ip     (l_ip),
    .ret_cs     (l_cs),
    .ret_flags  (l_flags),
    .ret_sp     (l_sp),
    .ret_ss     (l_ss),
    .addr       (wr_addr),
    .data       (wr_data)
  );

  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = '0;
    case (state)
      S_RQ_GLO: begin rd_valid = 1'b1; rd_addr = g_addr;            end
      S_RQ_GHI: begin rd_valid = 1'b1; rd_addr = g_addr + XLEN'(8); end
      S_RQ_CD:  begin rd_valid = 1'b1; rd_addr = cd_addr;           end
      default:  ;
    endcase
  end

  assign wr_valid       = (state == S_WRITE);
  assign ev_accept      = (state == S_IDLE) && start;
  assign ev_gate_fault  = (state == S_CHK_GATE) && !type_ok;
  assign ev_stack_fault = (state == S_CHK_STK) && stack_switch;
  assign ev_wr_beat     = wr_valid && wr_ready;
  assign ev_commit      = ev_wr_beat && (wr_idx == IDX_W'(FRAME_WORDS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      l_vec     <= '0;
      l_tbl     <= '0;
      l_ltab    <= '0;
      l_gtab    <= '0;
      l_ip      <= '0;
      l_sp      <= '0;
      l_flags   <= '0;
      l_cs      <= '0;
      l_ss      <= '0;
      gate_lo   <= '0;
      gate_hi   <= '0;
      code_desc <= '0;
      wr_idx    <= '0;
      done_q    <= 1'b0;
      fault_q   <= FLT_NONE;
      ip_q      <= '0;
      sp_q      <= '0;
      flags_q   <= '0;
      cs_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          l_vec   <= vector;
          l_tbl   <= vec_tbl_base;
          l_ltab  <= local_tbl_base;
          l_gtab  <= global_tbl_base;
          l_ip    <= cur_ip;
          l_sp    <= cur_sp;
          l_flags <= cur_flags;
          l_cs    <= cur_cs;
          l_ss    <= cur_ss;
          fault_q <= FLT_NONE;
          state   <= S_RQ_GLO;
        end
        S_RQ_GLO: if (rd_ready) state <= S_WT_GLO;
        S_WT_GLO: if (rd_rvalid) begin
          gate_lo <= rd_rdata;
          state   <= S_RQ_GHI;
        end
        S_RQ_GHI: if (rd_ready) state <= S_WT_GHI;
        S_WT_GHI: if (rd_rvalid) begin
          gate_hi <= rd_rdata;
          state   <= S_CHK_GATE;
        end
        S_CHK_GATE: begin
          if (!type_ok) begin
            fault_q <= FLT_GP;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_RQ_CD;
          end
        end
        S_RQ_CD: if (rd_ready) state <= S_WT_CD;
        S_WT_CD: if (rd_rvalid) begin
          code_desc <= rd_rdata;
          state     <= S_CHK_STK;
        end
        S_CHK_STK: begin
          if (stack_switch) begin
            fault_q <= FLT_UNSUP;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end else begin
            wr_idx <= '0;
            state  <= S_WRITE;
          end
        end
        S_WRITE: if (wr_ready) begin
          if (wr_idx == IDX_W'(FRAME_WORDS-1)) begin
            ip_q    <= gf.target;
            cs_q    <= gf.sel;
            sp_q    <= frame_base;
            flags_q <= tgt_flags;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end else begin
            wr_idx <= wr_idx + IDX_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign done       = done_q;
  assign fault_code = fault_q;
  assign new_ip     = ip_q;
  assign new_cs     = cs_q;
  assign new_sp     = sp_q;
  assign new_flags  = flags_q;
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  fault_code,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [63:0] rd_addr,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [63:0] wr_data,
  input logic [63:0] new_ip,
  input logic [15:0] new_cs,
  input logic [63:0] new_sp,
  input logic [63:0] new_flags,
  input logic        ev_gate_fault,
  input logic        ev_stack_fault,
  input logic        ev_commit
);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid));
  assert_gp_code_R2: assert property (@(posedge clk) disable iff (rst)
    ev_gate_fault |=> (done && fault_code == 2'd1));
  assert_unsup_code_R5: assert property (@(posedge clk) disable iff (rst)
    ev_stack_fault |=> (done && fault_code == 2'd2));
  assert_commit_ok_R7: assert property (@(posedge clk) disable iff (rst)
    ev_commit |=> (done && fault_code == 2'd0));
  assert_sp_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == 2'd0) |-> (new_sp[3:0] == 4'd0));
  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == 2'd0) |-> (!new_flags[8] && !new_flags[14] && !new_flags[16]));
  assert_fault_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != 2'd0) |->
      ($stable(new_ip) && $stable(new_sp) && $stable(new_cs) && $stable(new_flags)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!busy && !done && fault_code == 2'd0));
endmodule

bind intr_dispatch_seq intr_dispatch_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .fault_code     (fault_code),
  .rd_valid       (rd_valid),
  .rd_ready       (rd_ready),
  .rd_addr        (rd_addr),
  .wr_valid       (wr_valid),
  .wr_ready       (wr_ready),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .new_ip         (new_ip),
  .new_cs         (new_cs),
  .new_sp         (new_sp),
  .new_flags      (new_flags),
  .ev_gate_fault  (ev_gate_fault),
  .ev_stack_fault (ev_stack_fault),
  .ev_commit      (ev_commit)
);

// File: tb/intr_dispatch_seq_bench.sv
module intr_dispatch_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [63:0] vec_tbl_base = '0, local_tbl_base = '0, global_tbl_base = '0;
  logic [63:0] cur_ip = '0, cur_sp = '0, cur_flags = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic        rd_valid, wr_valid, busy, done;
  logic [63:0] rd_addr, wr_addr, wr_data, new_ip, new_sp, new_flags;
  logic [15:0] new_cs;
  logic [1:0]  fault_code;
  logic        rd_ready, rd_rvalid, wr_ready;
  logic [63:0] rd_rdata;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  intr_dispatch_seq u_intr_dispatch_seq (
    .clk(clk), .rst(rst), .start(start), .vector(vector),
    .vec_tbl_base(vec_tbl_base), .local_tbl_base(local_tbl_base),
    .global_tbl_base(global_tbl_base), .cur_ip(cur_ip), .cur_sp(cur_sp),
    .cur_cs(cur_cs), .cur_ss(cur_ss), .cur_flags(cur_flags),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .fault_code(fault_code),
    .new_ip(new_ip), .new_cs(new_cs), .new_sp(new_sp), .new_flags(new_flags)
  );

  // ---------------- memory model ----------------
  logic [63:0] m_gaddr, m_glo, m_ghi, m_cdaddr, m_cd;
  int rd_gap = 0, rd_lat = 0, wr_gap = 0;
  logic [63:0] rd_log [0:255];
  logic [63:0] wa_log [0:255];
  logic [63:0] wd_log [0:255];
  int rd_n = 0, wr_n = 0;
  int rd_wait = 0, rd_cnt = 0, wr_wait = 0;
  logic rd_pend = 1'b0;
  logic [63:0] rd_paddr = '0;

  function automatic logic [63:0] lookup(input logic [63:0] a);
    if (a == m_gaddr)          return m_glo;
    if (a == m_gaddr + 64'd8)  return m_ghi;
    if (a == m_cdaddr)         return m_cd;
    return 64'hDEAD_BEEF_DEAD_BEEF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rd_ready <= 1'b0; rd_rvalid <= 1'b0; rd_pend <= 1'b0; rd_wait <= 0;
      rd_rdata <= '0;
    end else begin
      rd_rvalid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_ready <= 1'b0; rd_pend <= 1'b1; rd_cnt <= rd_lat; rd_paddr <= rd_addr;
        rd_log[rd_n[7:0]] <= rd_addr; rd_n <= rd_n + 1;
      end else if (rd_pend) begin
        if (rd_cnt == 0) begin
          rd_rvalid <= 1'b1; rd_rdata <= lookup(rd_paddr); rd_pend <= 1'b0;
        end else rd_cnt <= rd_cnt - 1;
      end else if (rd_valid) begin
        if (rd_wait >= rd_gap) begin rd_ready <= 1'b1; rd_wait <= 0; end
        else rd_wait <= rd_wait + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      wr_ready <= 1'b0; wr_wait <= 0;
    end else if (wr_valid && wr_ready) begin
      wr_ready <= 1'b0;
      wa_log[wr_n[7:0]] <= wr_addr; wd_log[wr_n[7:0]] <= wr_data; wr_n <= wr_n + 1;
    end else if (wr_valid) begin
      if (wr_wait >= wr_gap) begin wr_ready <= 1'b1; wr_wait <= 0; end
      else wr_wait <= wr_wait + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // gate low word: offset[31:16] | present/dpl nibble | type | 0 | stack index | selector | offset[15:0]
  function automatic logic [63:0] mk_lo(input logic [63:0] off, input logic [15:0] sel,
                                        input logic [2:0] ist, input logic [3:0] gt);
    return {off[31:16], 4'h8, gt, 5'd0, ist, sel, off[15:0]};
  endfunction

  function automatic logic [63:0] mk_cd(input logic [1:0] dpl);
    return {17'h0, dpl, 45'h0};
  endfunction

  function automatic logic [63:0] exp_sp(input logic [63:0] sp);
    logic [63:0] t;
    t = sp - 64'd40;
    return (t >> 4) << 4;
  endfunction

  function automatic logic [63:0] exp_fl(input logic [63:0] f, input logic ie_keep);
    logic [63:0] m;
    m = 64'h0001_4100 | (ie_keep ? 64'h0 : 64'h200);
    return f & ~m;
  endfunction

  task automatic setup(input logic [7:0] v, input logic [63:0] tb, input logic [63:0] off,
                       input logic [15:0] sel, input logic [2:0] ist, input logic [3:0] gt,
                       input logic [1:0] dpl);
    vector = v; vec_tbl_base = tb;
    m_gaddr = tb + {52'h0, v, 4'h0};
    m_glo = mk_lo(off, sel, ist, gt);
    m_ghi = {32'h0, off[63:32]};
    m_cdaddr = (sel[2] ? local_tbl_base : global_tbl_base) + {48'h0, sel & 16'hFFF8};
    m_cd = mk_cd(dpl);
  endtask

  task automatic fire();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check64(req, "done arrives", {63'h0, done}, 64'h1);
  endtask

  task automatic check_success(input string tag, input logic [63:0] off, input logic [15:0] sel,
                               input logic ie_keep, input int rd0, input int wr0);
    logic [63:0] nsp;
    nsp = exp_sp(cur_sp);
    check64("R10", {tag, " fault none"}, {62'h0, fault_code}, 64'h0);
    check64("R10", {tag, " busy low at done"}, {63'h0, busy}, 64'h0);
    check64("R4", {tag, " new_ip"}, new_ip, off);
    check64("R4", {tag, " new_cs"}, {48'h0, new_cs}, {48'h0, sel});
    check64("R6", {tag, " new_sp"}, new_sp, nsp);
    check64("R8", {tag, " new_flags"}, new_flags, exp_fl(cur_flags, ie_keep));
    check64("R1", {tag, " read count"}, 64'(rd_n - rd0), 64'd3);
    check64("R1", {tag, " gate lo addr"}, rd_log[rd0[7:0]], m_gaddr);
    check64("R1", {tag, " gate hi addr"}, rd_log[8'(rd0 + 1)], m_gaddr + 64'd8);
    check64("R3", {tag, " code desc addr"}, rd_log[8'(rd0 + 2)], m_cdaddr);
    check64("R7", {tag, " write count"}, 64'(wr_n - wr0), 64'd5);
    for (int i = 0; i < 5; i++)
      check64("R7", {tag, " frame addr"}, wa_log[8'(wr0 + i)], nsp + 64'(8 * i));
    check64("R7", {tag, " frame ip"}, wd_log[wr0[7:0]], cur_ip);
    check64("R7", {tag, " frame cs"}, wd_log[8'(wr0 + 1)], {48'h0, cur_cs});
    check64("R7", {tag, " frame flags"}, wd_log[8'(wr0 + 2)], cur_flags);
    check64("R7", {tag, " frame sp"}, wd_log[8'(wr0 + 3)], cur_sp);
    check64("R7", {tag, " frame ss"}, wd_log[8'(wr0 + 4)], {48'h0, cur_ss});
    @(negedge clk);
    check64("R10", {tag, " done is a pulse"}, {63'h0, done}, 64'h0);
  endtask

  task automatic check_fault(input string req, input string tag, input logic [1:0] code,
                             input int wr0, input logic [63:0] ip0, input logic [63:0] sp0,
                             input logic [15:0] cs0, input logic [63:0] fl0);
    check64(req, {tag, " fault code"}, {62'h0, fault_code}, {62'h0, code});
    check64(req, {tag, " no writes"}, 64'(wr_n - wr0), 64'd0);
    check64("R9", {tag, " ip kept"}, new_ip, ip0);
    check64("R9", {tag, " sp kept"}, new_sp, sp0);
    check64("R9", {tag, " cs kept"}, {48'h0, new_cs}, {48'h0, cs0});
    check64("R9", {tag, " flags kept"}, new_flags, fl0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check64("R12", "busy after reset", {63'h0, busy}, 64'h0);
    check64("R12", "done after reset", {63'h0, done}, 64'h0);
    check64("R12", "fault after reset", {62'h0, fault_code}, 64'h0);
    check64("R12", "new_ip after reset", new_ip, 64'h0);
    check64("R12", "new_sp after reset", new_sp, 64'h0);
    check64("R11", "no request at idle", {62'h0, rd_valid, wr_valid}, 64'h0);
  endtask

  task automatic t_intr_gate_global();
    int rd0 = rd_n, wr0 = wr_n;
    global_tbl_base = 64'h0000_0000_0002_0000; local_tbl_base = 64'h0000_0000_0003_0000;
    cur_ip = 64'h0000_0000_0040_1000; cur_sp = 64'h0000_7FFF_0000_010C;
    cur_cs = 16'h0008; cur_ss = 16'h0010; cur_flags = 64'h0000_0000_0005_4302;
    rd_gap = 0; rd_lat = 0; wr_gap = 0;
    setup(8'h21, 64'h0000_0000_0010_0000, 64'hFFFF_8000_1234_5678, 16'h0010, 3'd0, 4'hE, 2'd0);
    fire();
    check64("R10", "busy after start", {63'h0, busy}, 64'h1);
    wait_done("R10");
    check_success("intr", 64'hFFFF_8000_1234_5678, 16'h0010, 1'b0, rd0, wr0);
  endtask

  task automatic t_trap_gate_local();
    int rd0 = rd_n, wr0 = wr_n;
    cur_ip = 64'h0000_1234_5678_9ABC; cur_sp = 64'h0000_0000_0080_0000;
    cur_cs = 16'h0033; cur_ss = 16'h002B; cur_flags = 64'h0000_0000_0001_4302;
    rd_gap = 2; rd_lat = 3; wr_gap = 2;
    setup(8'hFF, 64'h0000_0000_00AB_C000, 64'h0123_4567_89AB_CDEF, 16'h004F, 3'd0, 4'hF, 2'd3);
    fire();
    wait_done("R10");
    check_success("trap", 64'h0123_4567_89AB_CDEF, 16'h004F, 1'b1, rd0, wr0);
  endtask

  task automatic t_bad_type();
    int rd0 = rd_n, wr0 = wr_n;
    logic [63:0] ip0 = new_ip, sp0 = new_sp, fl0 = new_flags;
    logic [15:0] cs0 = new_cs;
    rd_gap = 1; rd_lat = 1;
    setup(8'h0D, 64'h0000_0000_0010_0000, 64'h1111_2222_3333_4444, 16'h0010, 3'd0, 4'hC, 2'd0);
    cur_cs = 16'h0008;
    fire();
    wait_done("R2");
    check_fault("R2", "type C", 2'd1, wr0, ip0, sp0, cs0, fl0);
    check64("R2", "type C reads gate only", 64'(rd_n - rd0), 64'd2);
    setup(8'h0E, 64'h0000_0000_0010_0000, 64'h1111_2222_3333_4444, 16'h0010, 3'd0, 4'h6, 2'd0);
    fire();
    wait_done("R2");
    check_fault("R2", "type 6", 2'd1, wr0, ip0, sp0, cs0, fl0);
  endtask

  task automatic t_stack_index();
    int wr0 = wr_n;
    logic [63:0] ip0 = new_ip, sp0 = new_sp, fl0 = new_flags;
    logic [15:0] cs0 = new_cs;
    rd_gap = 0; rd_lat = 2;
    cur_cs = 16'h0008;
    setup(8'h02, 64'h0000_0000_0010_0000, 64'h5555_6666_7777_8888, 16'h0010, 3'd2, 4'hE, 2'd0);
    fire();
    wait_done("R5");
    check_fault("R5", "stack index 2", 2'd2, wr0, ip0, sp0, cs0, fl0);
  endtask

  task automatic t_priv_change();
    int rd0 = rd_n, wr0 = wr_n;
    logic [63:0] ip0 = new_ip, sp0 = new_sp, fl0 = new_flags;
    logic [15:0] cs0 = new_cs;
    cur_cs = 16'h0033;
    setup(8'h80, 64'h0000_0000_0010_0000, 64'h5555_6666_7777_8888, 16'h0014, 3'd0, 4'hE, 2'd0);
    fire();
    wait_done("R5");
    check_fault("R5", "privilege change", 2'd2, wr0, ip0, sp0, cs0, fl0);
    check64("R3", "local table selected", rd_log[8'(rd0 + 2)], m_cdaddr);
  endtask

  task automatic t_start_while_busy();
    int rd0 = rd_n, wr0 = wr_n;
    logic [63:0] first_gaddr;
    global_tbl_base = 64'h0000_0000_0002_0000;
    cur_ip = 64'h0000_0000_0000_7777; cur_sp = 64'h0000_0000_0000_1000;
    cur_cs = 16'h0008; cur_ss = 16'h0000; cur_flags = 64'h0000_0000_0000_0202;
    rd_gap = 1; rd_lat = 3; wr_gap = 0;
    setup(8'h40, 64'h0000_0000_0010_0000, 64'h0000_0000_00C0_FFEE, 16'h0008, 3'd0, 4'hE, 2'd0);
    first_gaddr = m_gaddr;
    fire();
    @(negedge clk); @(negedge clk);
    vector = 8'h05; cur_ip = 64'h9999; start = 1'b1;
    @(negedge clk); start = 1'b0;
    vector = 8'h40; cur_ip = 64'h0000_0000_0000_7777;
    wait_done("R10");
    check64("R10", "ignored start: first read addr", rd_log[rd0[7:0]], first_gaddr);
    check_success("busy-ignore", 64'h0000_0000_00C0_FFEE, 16'h0008, 1'b0, rd0, wr0);
    check64("R10", "no second sequence", {63'h0, busy}, 64'h0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_intr_gate_global();
        t_trap_gate_local();
        t_bad_type();
        t_stack_index();
        t_priv_change();
        t_start_while_busy();
      end
      begin
        while (wd < 100000) begin @(negedge clk); wd++; end
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule